// File: doc/BRIEF.md
# Converter control and result formatter

This block is the digital control side of a shared analog converter that can run either as an ADC or as a DAC. Software reaches it through a byte-wide register port with three locations: a control byte, a low data byte and a high data byte. The control byte holds an enable, a direction select, a justify select, a start/busy bit, a completion flag and a three-bit conversion clock select. A prescaler turns the chosen clock source into a one-cycle conversion tick. The tick comes either from a divided internal oscillator strobe or from the system clock divided by a power of two.

A sequencer starts each conversion with a one-cycle start strobe to the external converter and then waits for its done strobe. A conversion can be started by a software write, by a hardware trigger pin, or, in DAC direction, by writing the high data byte. In ADC direction, the 10-bit two's complement raw result is formatted into a 16-bit word when the conversion finishes. The word is either right-aligned with sign extension or left-aligned with zero fill. The converter model in the bench counts 13 conversion ticks between start and done.

Top module: `cvt_ctrl_unit`

## Requirements
- R1: After reset, all three registers read 0x00 and `irq` is low. The addresses are control = 0, low data byte (bits 7..0) = 1 and high data byte (bits 15..8) = 2.
- R2: The flag (control bit 4, mirrored on `irq`) is set in the cycle a conversion finishes. It is cleared by a one-cycle `irq_ack`, and a finish in the same cycle as an acknowledge wins.
- R3: With `hw_trig_mode` low and enable (bit 0) set, writing 1 to bit 3 starts a conversion. Bit 3 then reads 1 until the conversion finishes and reads 0 afterwards.
- R4: With `hw_trig_mode` high, writes to bit 3 start nothing. A one-cycle `hw_trig` starts a conversion, and bit 3 shows busy until it finishes.
- R5: While enable is 0, `conv_tick` stays low, and both software starts and hardware triggers are ignored.
- R6: Clearing enable while a conversion runs returns the block to idle, with bit 3 reading 0 and no flag set.
- R7: In ADC direction (bit 1 = 0) with justify (bit 2) = 0, the result is the raw value sign-extended to 16 bits.
- R8: In ADC direction with justify = 1, the result is the raw value in bits 15..6, with bits 5..0 equal to zero.
- R9: The clock select (bits 7..5) sets the tick rate. Code 0 gives one tick per 4 oscillator strobes, and code k from 1 to 7 gives one tick every 2^k system clocks.
- R10: In DAC direction, a write to the high data byte starts an update. `dac_data` carries word bits 9..0 when justify = 0 and word bits 15..6 when justify = 1. The data bytes are not overwritten when the update finishes.
- R11: A start request that arrives while busy is ignored, and the running conversion is neither restarted nor given a second start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| irq | output | 1 | Completion flag |
| hw_trig_mode | input | 1 | Selects hardware-trigger starts |
| hw_trig | input | 1 | Hardware start trigger |
| osc_tick | input | 1 | Internal oscillator strobe, one cycle wide |
| conv_tick | output | 1 | Conversion clock enable |
| conv_start | output | 1 | Start strobe to the converter |
| conv_dir_dac | output | 1 | Converter direction, 1 = DAC |
| conv_done | input | 1 | Converter done strobe |
| conv_raw | input | RAW_W | Raw signed converter result |
| dac_data | output | RAW_W | Value driven to the converter in DAC direction |

## Verification
The bench builds the block with its defaults: a 10-bit raw result and an oscillator divide of 4. It pulses `osc_tick` every third cycle, so clock code 0 gives a 12-cycle tick period that no system-clock division can produce. The longest division makes a conversion about 1700 cycles long, so every clock code can run a full conversion. The 10-bit width puts the sign bit and the 6-bit padding at both extremes of the result vectors.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } seq_state_t;

    // control byte layout
    localparam int CTL_EN     = 0;
    localparam int CTL_DAC    = 1;
    localparam int CTL_LJ     = 2;
    localparam int CTL_GO     = 3;
    localparam int CTL_FLAG   = 4;
    localparam int CTL_SEL_LO = 5;
    localparam int CLK_SEL_W  = 3;

    localparam logic [1:0] ADDR_CTL = 2'd0;
    localparam logic [1:0] ADDR_LO  = 2'd1;
    localparam logic [1:0] ADDR_HI  = 2'd2;

endpackage

// File: rtl/cvt_prescaler.sv
module cvt_prescaler #(
    parameter int SEL_W   = 3,
    parameter int OSC_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             osc_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = (1 << SEL_W) - 1;
    localparam int OSC_W = (OSC_DIV > 1) ? $clog2(OSC_DIV) : 1;

    logic [CNT_W-1:0] sys_cnt;
    logic [OSC_W-1:0] osc_cnt;
    logic [CNT_W-1:0] mask;
    logic             osc_wrap;

    assign osc_wrap = (osc_cnt == OSC_W'(OSC_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sys_cnt <= '0;
            osc_cnt <= '0;
        end else begin
            sys_cnt <= sys_cnt + 1'b1;
            if (osc_tick) begin
                osc_cnt <= osc_wrap ? '0 : osc_cnt + 1'b1;
            end
        end
    end

    // one mask bit per divider stage below the selected power of two
    for (genvar g = 0; g < CNT_W; g++) begin : g_mask
        assign mask[g] = (32'(sel) > g);
    end

    always_comb begin
        if (!run) begin
            tick = 1'b0;
        end else if (sel == '0) begin
            tick = osc_tick && osc_wrap;
        end else begin
            tick = ((sys_cnt & mask) == mask);
        end
    end

endmodule

// File: rtl/cvt_formatter.sv
module cvt_formatter #(
    parameter int RAW_W  = 10,
    parameter int WORD_W = 16
) (
    input  logic              left_just,
    input  logic [RAW_W-1:0]  raw,
    input  logic [WORD_W-1:0] dac_word,
    output logic [WORD_W-1:0] adc_word,
    output logic [RAW_W-1:0]  dac_out
);
    localparam int PAD = WORD_W - RAW_W;

    always_comb begin
        if (left_just) begin
            adc_word = {raw, {PAD{1'b0}}};
            dac_out  = dac_word[WORD_W-1 -: RAW_W];
        end else begin
            adc_word = {{PAD{raw[RAW_W-1]}}, raw};
            dac_out  = dac_word[RAW_W-1:0];
        end
    end

endmodule

// File: rtl/cvt_sequencer.sv
module cvt_sequencer
    import cvt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic req,
    input  logic conv_done,
    output logic conv_start,
    output logic busy,
    output logic finish
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (enable && req) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = enable ? ST_WAIT : ST_IDLE;
            ST_WAIT:   if (!enable || conv_done) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        conv_start = (state_q == ST_LAUNCH) && enable;
        busy       = (state_q != ST_IDLE);
        finish     = (state_q == ST_WAIT) && enable && conv_done;
    end

endmodule

// File: rtl/cvt_ctrl_unit.sv
module cvt_ctrl_unit
    import cvt_pkg::*;
#(
    parameter int RAW_W   = 10,
    parameter int OSC_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             irq_ack,
    output logic             irq,
    input  logic             hw_trig_mode,
    input  logic             hw_trig,
    input  logic             osc_tick,
    output logic             conv_tick,
    output logic             conv_start,
    output logic             conv_dir_dac,
    input  logic             conv_done,
    input  logic [RAW_W-1:0] conv_raw,
    output logic [RAW_W-1:0] dac_data
);
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    logic                 en_q, dac_q, lj_q, flag_q;
    logic [CLK_SEL_W-1:0] sel_q;
    logic [WORD_W-1:0]    data_q;
    logic [WORD_W-1:0]    adc_word;
    logic                 wr_ctl, wr_lo, wr_hi;
    logic                 start_req, seq_busy, seq_finish;
    logic                 unused_flag_wr;

    assign unused_flag_wr = bus_wdata[CTL_FLAG];

    assign wr_ctl = bus_wr && (bus_addr == ADDR_CTL);
    assign wr_lo  = bus_wr && (bus_addr == ADDR_LO);
    assign wr_hi  = bus_wr && (bus_addr == ADDR_HI);

    assign start_req = (!hw_trig_mode && wr_ctl && bus_wdata[CTL_GO])
                     || (hw_trig_mode && hw_trig)
                     || (dac_q && wr_hi);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            dac_q  <= 1'b0;
            lj_q   <= 1'b0;
            sel_q  <= '0;
            flag_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (wr_ctl) begin
                en_q  <= bus_wdata[CTL_EN];
                dac_q <= bus_wdata[CTL_DAC];
                lj_q  <= bus_wdata[CTL_LJ];
                sel_q <= bus_wdata[CTL_SEL_LO +: CLK_SEL_W];
            end
            if (seq_finish) begin
                flag_q <= 1'b1;
            end else if (irq_ack) begin
                flag_q <= 1'b0;
            end
            if (seq_finish && !dac_q) begin
                data_q <= adc_word;
            end else if (dac_q) begin
                if (wr_lo) data_q[BYTE_W-1:0]      <= bus_wdata;
                if (wr_hi) data_q[WORD_W-1:BYTE_W] <= bus_wdata;
            end
        end
    end

    cvt_prescaler #(
        .SEL_W   (CLK_SEL_W),
        .OSC_DIV (OSC_DIV)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en_q),
        .osc_tick (osc_tick),
        .sel      (sel_q),
        .tick     (conv_tick)
    );

    cvt_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (en_q),
        .req        (start_req),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .busy       (seq_busy),
        .finish     (seq_finish)
    );

    cvt_formatter #(
        .RAW_W  (RAW_W),
        .WORD_W (WORD_W)
    ) u_fmt (
        .left_just (lj_q),
        .raw       (conv_raw),
        .dac_word  (data_q),
        .adc_word  (adc_word),
        .dac_out   (dac_data)
    );

    always_comb begin
        case (bus_addr)
            ADDR_CTL: bus_rdata = {sel_q, flag_q, seq_busy, lj_q, dac_q, en_q};
            ADDR_LO:  bus_rdata = data_q[BYTE_W-1:0];
            ADDR_HI:  bus_rdata = data_q[WORD_W-1:BYTE_W];
            default:  bus_rdata = '0;
        endcase
    end

    assign irq          = flag_q;
    assign conv_dir_dac = dac_q;

endmodule

// File: rtl/cvt_ctrl_sva.sv
module cvt_ctrl_sva (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic busy,
    input logic irq,
    input logic irq_ack,
    input logic conv_start,
    input logic conv_done,
    input logic conv_tick
);
    AST_TICK_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !conv_tick); // R5

    AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !$past(busy)); // R11

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> busy); // R3

    AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(conv_done)); // R2

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack && !conv_done) |=> !irq); // R2

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !en) |=> !busy); // R6
endmodule

bind cvt_ctrl_unit cvt_ctrl_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_q),
    .busy       (seq_busy),
    .irq        (irq),
    .irq_ack    (irq_ack),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .conv_tick  (conv_tick)
);

// File: tb/cvt_ctrl_unit_tb_top.sv
`timescale 1ns/1ps
module cvt_ctrl_unit_tb_top;
    localparam int RAW_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_wr = 1'b0;
    logic [1:0]       bus_addr = '0;
    logic [7:0]       bus_wdata = '0;
    logic [7:0]       bus_rdata;
    logic             irq_ack = 1'b0;
    logic             irq;
    logic             hw_trig_mode = 1'b0;
    logic             hw_trig = 1'b0;
    logic             osc_tick = 1'b0;
    logic             conv_tick, conv_start, conv_dir_dac, conv_done;
    logic [RAW_W-1:0] conv_raw = '0;
    logic [RAW_W-1:0] dac_data;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cvt_ctrl_unit #(.RAW_W(RAW_W), .OSC_DIV(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
        .irq(irq), .hw_trig_mode(hw_trig_mode), .hw_trig(hw_trig),
        .osc_tick(osc_tick), .conv_tick(conv_tick), .conv_start(conv_start),
        .conv_dir_dac(conv_dir_dac), .conv_done(conv_done),
        .conv_raw(conv_raw), .dac_data(dac_data)
    );

    // behavioural converter: done after 13 ticks
    logic             stub_active = 1'b0;
    int               stub_rem = 0;
    int               n_starts = 0;
    logic [RAW_W-1:0] dac_seen = '0;

    always @(posedge clk) begin
        if (conv_start) begin
            stub_active <= 1'b1;
            stub_rem    <= 13;
            n_starts    <= n_starts + 1;
            dac_seen    <= dac_data;
        end else if (stub_active && conv_done) begin
            stub_active <= 1'b0;
        end else if (stub_active && conv_tick) begin
            stub_rem <= stub_rem - 1;
        end
    end
    assign conv_done = stub_active && (stub_rem == 0);

    initial begin
        forever begin
            repeat (2) @(negedge clk);
            osc_tick = 1'b1;
            @(negedge clk);
            osc_tick = 1'b0;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic logic [7:0] ctl(input int sel, input bit go, input bit lj,
                                       input bit dac, input bit en);
        return {3'(sel), 1'b0, go, lj, dac, en};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_irq(input int limit, output bit seen);
        int n = 0;
        seen = 0;
        while (n < limit && !seen) begin
            @(negedge clk);
            #1 seen = irq;
            n++;
        end
    endtask

    task automatic ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        #1;
    endtask

    task automatic tick_period(input int sel, output int period);
        int first = -1;
        period = -1;
        wr(2'd0, ctl(sel, 0, 0, 0, 1));
        for (int n = 0; n < 400 && period < 0; n++) begin
            @(negedge clk);
            #1;
            if (conv_tick) begin
                if (first < 0) first = n;
                else period = n - first;
            end
        end
    endtask

    // {justify, clock select, raw, expected 16-bit word}
    localparam logic [29:0] VEC [6] = '{
        {1'b0, 3'd1, 10'h1FF, 16'h01FF},
        {1'b0, 3'd2, 10'h200, 16'hFE00},
        {1'b1, 3'd3, 10'h3FF, 16'hFFC0},
        {1'b1, 3'd0, 10'h155, 16'h5540},
        {1'b0, 3'd7, 10'h3FF, 16'hFFFF},
        {1'b1, 3'd4, 10'h001, 16'h0040}
    };

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d, lo, hi;
        bit seen;
        int per, s0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, d); chk("R1 ctrl", d, 0);
        rd(2'd1, d); chk("R1 lo", d, 0);
        rd(2'd2, d); chk("R1 hi", d, 0);
        chk("R1 irq", irq, 0);

        // R5 disabled: no ticks, no starts
        per = 0;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk); #1;
            if (conv_tick) per++;
        end
        chk("R5 tick while disabled", per, 0);
        wr(2'd0, ctl(1, 1, 0, 0, 0));
        rd(2'd0, d); chk("R5 sw start ignored", d[3], 0);
        hw_trig_mode = 1'b1;
        @(negedge clk); hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
        rd(2'd0, d); chk("R5 hw trigger ignored", d[3], 0);
        hw_trig_mode = 1'b0;

        // R9 tick rates
        tick_period(0, per); chk("R9 code 0 oscillator", per, 12);
        for (int s = 1; s < 8; s++) begin
            tick_period(s, per); chk("R9 system division", per, 1 << s);
        end

        // R7 R8 R3 R2: table of conversions
        foreach (VEC[i]) begin
            conv_raw = VEC[i][25:16];
            wr(2'd0, ctl(VEC[i][28:26], 0, VEC[i][29], 0, 1));
            wr(2'd0, ctl(VEC[i][28:26], 1, VEC[i][29], 0, 1));
            rd(2'd0, d); chk("R3 busy during run", d[3], 1);
            wait_irq(4000, seen); chk("R2 flag on finish", seen, 1);
            rd(2'd0, d); chk("R3 busy cleared", d[3], 0);
            rd(2'd1, lo); rd(2'd2, hi);
            chk(VEC[i][29] ? "R8 left word" : "R7 right word", {hi, lo}, VEC[i][15:0]);
            ack(); chk("R2 ack clears", irq, 0);
        end

        // R11 start while busy
        s0 = n_starts;
        conv_raw = 10'h0AA;
        wr(2'd0, ctl(3, 1, 0, 0, 1));
        repeat (40) @(negedge clk);
        wr(2'd0, ctl(3, 1, 0, 0, 1));
        wait_irq(4000, seen);
        chk("R11 single start", n_starts - s0, 1);
        rd(2'd1, lo); chk("R11 result", lo, 8'hAA);
        ack();

        // R4 hardware trigger
        hw_trig_mode = 1'b1;
        conv_raw = 10'h2F0;
        wr(2'd0, ctl(2, 1, 0, 0, 1));
        rd(2'd0, d); chk("R4 sw start ignored", d[3], 0);
        @(negedge clk); hw_trig = 1'b1; @(negedge clk); hw_trig = 1'b0;
        rd(2'd0, d); chk("R4 busy on trigger", d[3], 1);
        wait_irq(4000, seen); chk("R4 completes", seen, 1);
        rd(2'd2, hi); rd(2'd1, lo); chk("R4 result", {hi, lo}, 16'hFEF0);
        ack();
        hw_trig_mode = 1'b0;

        // R6 abort
        wr(2'd0, ctl(5, 1, 0, 0, 1));
        repeat (100) @(negedge clk);
        wr(2'd0, ctl(5, 0, 0, 0, 0));
        rd(2'd0, d); chk("R6 idle after disable", d[3], 0);
        repeat (600) @(negedge clk);
        chk("R6 no flag", irq, 0);

        // R10 DAC updates
        wr(2'd0, ctl(1, 0, 0, 1, 1));
        chk("R10 direction pin", conv_dir_dac, 1);
        wr(2'd1, 8'h34);
        wr(2'd2, 8'h02);
        wait_irq(4000, seen); chk("R10 update finishes", seen, 1);
        chk("R10 right word to converter", dac_seen, 10'h234);
        rd(2'd1, lo); rd(2'd2, hi); chk("R10 bytes kept", {hi, lo}, 16'h0234);
        ack();
        wr(2'd0, ctl(1, 0, 1, 1, 1));
        wr(2'd1, 8'hC0);
        wr(2'd2, 8'hAB);
        wait_irq(4000, seen);
        chk("R10 left word to converter", dac_seen, 10'h2AF);
        ack();

        finished = 1;
        summary();
        $finish;
    end

endmodule